// File: doc/BRIEF.md
# Linear Frequency Sweep Sequencer

This block feeds the register write port of a DDS whose output frequency is set by a phase-increment word. Once it has been started, it produces a stream of tuning words with no help from a host. It has two modes. The ramp mode gives a linear chirp: the word grows by a fixed step on every clock, from a start value up to an end value. The schedule mode plays back a short table of segments. Each segment has a frequency word and a dwell count in clock cycles.

The address output is tied to zero, so every write goes to the phase-increment register. The write strobe stays high on every clock of a run, which means the DDS is rewritten each cycle. Take a 500 MHz sample clock and a 32-bit accumulator. A step of 85899 raises the frequency by about 10 kHz per clock, and a full 0 to 250 MHz sweep then lasts 50 µs. When the final word has been issued, the strobe drops, the last word stays on the data bus and a done flag rises.

Top module: `fsweep_seq`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the block returns to idle. After that edge `dds_we`=0, `done`=0 and `dds_data`=0.
- R2: `dds_addr` reads zero in every cycle.
- R3: A `go` pulse sampled in idle with `mode_sel`=0 (ramp) has these effects. In the next cycle `dds_we`=1 and `dds_data`=`ramp_lo`. In each cycle after that, the word grows by `ramp_step`.
- R4: A ramp word never goes above `ramp_hi` and never wraps. It clamps to `ramp_hi` when the sum would exceed it or overflow 32 bits.
- R5: The cycle after a ramp word at or above `ramp_hi` has been issued, `dds_we`=0 and `done`=1, and `dds_data` holds that last word.
- R6: A `go` pulse sampled in idle with `mode_sel`=1 (schedule) issues the segments in index order. Segment k supplies the word `seg_freq[k*32 +: 32]` and the dwell `seg_dwell[k*24 +: 24]`. Its word stays on `dds_data`, with `dds_we`=1, for exactly its dwell count of cycles.
- R7: A segment with a dwell count of zero ends the schedule. The segment before it is then the last one issued. If segment 0 has a zero dwell, `done`=1 the next cycle, no write is made and `dds_data` keeps its old value.
- R8: After the last table entry (index NSEG-1) has finished its dwell, the next cycle shows `dds_we`=0 and `done`=1.
- R9: A `go` pulse that arrives during a run is ignored. The run completes unchanged.
- R10: `done` stays high until the next accepted `go`. That `go` clears `done` and starts a new run.
- R11: A reset in the middle of a run stops it at once, with `dds_we`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, honoured only when no run is in progress |
| mode_sel | input | 1 | 0 = linear ramp, 1 = segment schedule |
| ramp_lo | input | 32 | First ramp word |
| ramp_hi | input | 32 | Final ramp word (clamp value) |
| ramp_step | input | 32 | Per-clock ramp increment |
| seg_freq | input | NSEG*32 | Packed segment frequency words, entry k at bits k*32 |
| seg_dwell | input | NSEG*24 | Packed segment dwell counts, entry k at bits k*24 |
| dds_addr | output | 2 | DDS register address, always zero |
| dds_we | output | 1 | DDS write strobe |
| dds_data | output | 32 | DDS write data (tuning word) |
| done | output | 1 | Run finished |

## Verification
Two things can land in the same cycle: the issue of a run's final word and a new start request. To provoke this, the bench raises `go` with the other mode selected in exactly the cycle that shows the clamped last ramp word. It then checks that the next cycle still brings `done` high with the strobe low and the word unchanged, and that no new run begins. A second collision happens when a ramp sum overflows 32 bits in the same cycle as the clamp. A start value close to the top of the range is used to provoke it, and the issued sequence is compared against a wide-sum model in the bench.

// File: rtl/fsweep_pkg.sv
package fsweep_pkg;

    localparam int WORD_W  = 32;
    localparam int DWELL_W = 24;
    localparam int NSEG    = 4;
    localparam int ADDR_W  = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RAMP  = 2'd1,
        ST_SCHED = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_t;

    typedef enum logic {
        MODE_RAMP  = 1'b0,
        MODE_SCHED = 1'b1
    } seq_mode_t;

endpackage

// File: rtl/ramp_step_unit.sv
module ramp_step_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] step,
    input  logic [W-1:0] hi,
    output logic [W-1:0] nxt,
    output logic         at_end
);
    logic [W:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, cur} + {1'b0, step};
        // clamp on carry-out or on passing the limit
        if (wide_sum[W] || (wide_sum[W-1:0] > hi))
            nxt = hi;
        else
            nxt = wide_sum[W-1:0];
        at_end = (cur >= hi);
    end
endmodule

// File: rtl/seg_select.sv
module seg_select #(
    parameter int NSEG    = 4,
    parameter int W       = 32,
    parameter int DW      = 24,
    parameter int IDX_W   = 3
) (
    input  logic [NSEG*W-1:0]  seg_freq,
    input  logic [NSEG*DW-1:0] seg_dwell,
    input  logic [IDX_W-1:0]   idx,
    output logic [W-1:0]       sel_word,
    output logic [DW-1:0]      sel_dwell
);
    logic [W-1:0]  words  [NSEG];
    logic [DW-1:0] dwells [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_unpack
        assign words[g]  = seg_freq[g*W +: W];
        assign dwells[g] = seg_dwell[g*DW +: DW];
    end

    // index past the table yields dwell 0, which ends the schedule
    always_comb begin
        sel_word  = '0;
        sel_dwell = '0;
        for (int k = 0; k < NSEG; k++) begin
            if (idx == IDX_W'(k)) begin
                sel_word  = words[k];
                sel_dwell = dwells[k];
            end
        end
    end
endmodule

// File: rtl/fsweep_seq.sv
module fsweep_seq
    import fsweep_pkg::*;
#(
    parameter int P_WORD_W  = fsweep_pkg::WORD_W,
    parameter int P_DWELL_W = fsweep_pkg::DWELL_W,
    parameter int P_NSEG    = fsweep_pkg::NSEG,
    parameter int P_ADDR_W  = fsweep_pkg::ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          go,
    input  logic                          mode_sel,
    input  logic [P_WORD_W-1:0]           ramp_lo,
    input  logic [P_WORD_W-1:0]           ramp_hi,
    input  logic [P_WORD_W-1:0]           ramp_step,
    input  logic [P_NSEG*P_WORD_W-1:0]    seg_freq,
    input  logic [P_NSEG*P_DWELL_W-1:0]   seg_dwell,
    output logic [P_ADDR_W-1:0]           dds_addr,
    output logic                          dds_we,
    output logic [P_WORD_W-1:0]           dds_data,
    output logic                          done
);
    localparam int IDX_W = $clog2(P_NSEG) + 1;

    seq_state_t             state;
    logic [IDX_W-1:0]       idx;
    logic [IDX_W-1:0]       lk_idx;
    logic [P_DWELL_W-1:0]   cnt;
    logic [P_WORD_W-1:0]    lk_word;
    logic [P_DWELL_W-1:0]   lk_dwell;
    logic [P_WORD_W-1:0]    ramp_nxt;
    logic                   ramp_end;

    assign dds_addr = '0;
    assign lk_idx   = (state == ST_SCHED) ? idx + IDX_W'(1) : '0;

    ramp_step_unit #(.W(P_WORD_W)) u_ramp (
        .cur    (dds_data),
        .step   (ramp_step),
        .hi     (ramp_hi),
        .nxt    (ramp_nxt),
        .at_end (ramp_end)
    );

    seg_select #(
        .NSEG (P_NSEG),
        .W    (P_WORD_W),
        .DW   (P_DWELL_W),
        .IDX_W(IDX_W)
    ) u_seg (
        .seg_freq (seg_freq),
        .seg_dwell(seg_dwell),
        .idx      (lk_idx),
        .sel_word (lk_word),
        .sel_dwell(lk_dwell)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            dds_we   <= 1'b0;
            done     <= 1'b0;
            dds_data <= '0;
            idx      <= '0;
            cnt      <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (go) begin
                        done <= 1'b0;
                        if (seq_mode_t'(mode_sel) == MODE_RAMP) begin
                            state    <= ST_RAMP;
                            dds_data <= ramp_lo;
                            dds_we   <= 1'b1;
                        end else if (lk_dwell == '0) begin
                            state  <= ST_DONE;
                            done   <= 1'b1;
                            dds_we <= 1'b0;
                        end else begin
                            state    <= ST_SCHED;
                            dds_data <= lk_word;
                            dds_we   <= 1'b1;
                            idx      <= '0;
                            cnt      <= lk_dwell - P_DWELL_W'(1);
                        end
                    end
                end
                ST_RAMP: begin
                    if (ramp_end) begin
                        state  <= ST_DONE;
                        dds_we <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        dds_data <= ramp_nxt;
                    end
                end
                ST_SCHED: begin
                    if (cnt != '0) begin
                        cnt <= cnt - P_DWELL_W'(1);
                    end else if (lk_dwell == '0) begin
                        state  <= ST_DONE;
                        dds_we <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        idx      <= idx + IDX_W'(1);
                        dds_data <= lk_word;
                        cnt      <= lk_dwell - P_DWELL_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5
    done_we_excl_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !dds_we);

    // R5
    we_fall_done_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(dds_we) && !$past(rst)) |-> done);

    // R3
    ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RAMP && $past(state == ST_RAMP) && dds_data != ramp_hi)
        |-> dds_data == $past(dds_data) + ramp_step);

    // R4
    ramp_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RAMP && $past(state == ST_RAMP))
        |-> (dds_data <= ramp_hi && dds_data >= $past(dds_data)));

    // R6
    dwell_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SCHED && $past(state == ST_SCHED) && $past(cnt) != '0)
        |-> $stable(dds_data));
endmodule

// File: tb/tb_fsweep_seq.sv
module tb_fsweep_seq;
    localparam int NS = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              go = 1'b0;
    logic              mode_sel = 1'b0;
    logic [31:0]       ramp_lo = '0, ramp_hi = '0, ramp_step = '0;
    logic [NS*32-1:0]  seg_freq = '0;
    logic [NS*24-1:0]  seg_dwell = '0;
    logic [1:0]        dds_addr;
    logic              dds_we;
    logic [31:0]       dds_data;
    logic              done;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    logic [31:0] fq [NS];
    logic [23:0] dw [NS];

    always #4 clk = ~clk;

    fsweep_seq dut (
        .clk(clk), .rst(rst), .go(go), .mode_sel(mode_sel),
        .ramp_lo(ramp_lo), .ramp_hi(ramp_hi), .ramp_step(ramp_step),
        .seg_freq(seg_freq), .seg_dwell(seg_dwell),
        .dds_addr(dds_addr), .dds_we(dds_we), .dds_data(dds_data), .done(done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            nerr = nerr + 1;
            nchk = nchk + 1;
            $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk = nchk + 1;
        if (act !== exp) begin
            nerr = nerr + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_go(input logic m);
        mode_sel = m;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic load_segs();
        for (int k = 0; k < NS; k++) begin
            seg_freq[k*32 +: 32]  = fq[k];
            seg_dwell[k*24 +: 24] = dw[k];
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 we", {31'b0, dds_we}, 32'd0);
        check("R1 done", {31'b0, done}, 32'd0);
        check("R1 data", dds_data, 32'd0);
        check("R2 addr", {30'b0, dds_addr}, 32'd0);
    endtask

    // R3 R4 R5: ramp against a wide-sum model
    task automatic run_ramp(input logic [31:0] lo, input logic [31:0] hi,
                            input logic [31:0] st, input int exp_words);
        logic [31:0] e;
        logic [32:0] s;
        int n;
        ramp_lo = lo; ramp_hi = hi; ramp_step = st;
        @(negedge clk);
        pulse_go(1'b0);
        e = lo;
        n = 0;
        for (int i = 0; i < 200; i++) begin
            check("R3 we", {31'b0, dds_we}, 32'd1);
            check("R3/R4 word", dds_data, e);
            check("R2 addr", {30'b0, dds_addr}, 32'd0);
            n++;
            if (e >= hi) break;
            s = {1'b0, e} + {1'b0, st};
            e = (s[32] || s[31:0] > hi) ? hi : s[31:0];
            @(negedge clk);
        end
        @(negedge clk);
        check("R5 we low", {31'b0, dds_we}, 32'd0);
        check("R5 done", {31'b0, done}, 32'd1);
        check("R5 hold", dds_data, e);
        check("R4 count", n, exp_words);
    endtask

    // R6 R7 R8: schedule
    task automatic run_sched(input int nseg_exp, input logic [31:0] prev);
        load_segs();
        @(negedge clk);
        pulse_go(1'b1);
        if (nseg_exp == 0) begin
            check("R7 done", {31'b0, done}, 32'd1);
            check("R7 no write", {31'b0, dds_we}, 32'd0);
            check("R7 data kept", dds_data, prev);
        end else begin
            for (int s = 0; s < nseg_exp; s++) begin
                for (int c = 0; c < int'(dw[s]); c++) begin
                    check("R6 we", {31'b0, dds_we}, 32'd1);
                    check("R6 word", dds_data, fq[s]);
                    @(negedge clk);
                end
            end
            check("R8 done", {31'b0, done}, 32'd1);
            check("R8 we low", {31'b0, dds_we}, 32'd0);
            check("R8 hold", dds_data, fq[nseg_exp-1]);
        end
    endtask

    // R9 R10: go in the final-word cycle is ignored, done holds, next go restarts
    task automatic t_busy_go();
        ramp_lo = 32'd0; ramp_hi = 32'd250; ramp_step = 32'd100;
        @(negedge clk);
        pulse_go(1'b0);
        repeat (3) @(negedge clk);
        check("R9 last word", dds_data, 32'd250);
        pulse_go(1'b1);
        check("R9 done", {31'b0, done}, 32'd1);
        check("R9 we low", {31'b0, dds_we}, 32'd0);
        check("R9 data", dds_data, 32'd250);
        @(negedge clk);
        check("R10 done held", {31'b0, done}, 32'd1);
        check("R10 data held", dds_data, 32'd250);
        ramp_lo = 32'd7; ramp_hi = 32'd9; ramp_step = 32'd1;
        pulse_go(1'b0);
        check("R10 done cleared", {31'b0, done}, 32'd0);
        check("R10 restart", dds_data, 32'd7);
        repeat (4) @(negedge clk);
    endtask

    // R11: reset during a run
    task automatic t_rst_mid();
        ramp_lo = 32'd5; ramp_hi = 32'd5000; ramp_step = 32'd10;
        @(negedge clk);
        pulse_go(1'b0);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 we", {31'b0, dds_we}, 32'd0);
        check("R11 done", {31'b0, done}, 32'd0);
        check("R11 data", dds_data, 32'd0);
        repeat (3) @(negedge clk);
        check("R11 stays idle", {31'b0, dds_we}, 32'd0);
    endtask

    initial begin
        t_reset();
        // 10 kHz per clock at 500 MHz: step 85899
        run_ramp(32'd1000, 32'd430595, 32'd85899, 7);
        // sum overflows 32 bits on the clamp cycle
        run_ramp(32'hFFFF_FF00, 32'hFFFF_FFF0, 32'h80, 3);
        // 120, 100, 75, 50 MHz at 500 MHz sample rate
        fq[0] = 32'd1030792151; fq[1] = 32'd858993459;
        fq[2] = 32'd644245094;  fq[3] = 32'd429496730;
        dw[0] = 24'd3; dw[1] = 24'd5; dw[2] = 24'd2; dw[3] = 24'd4;
        run_sched(4, 32'd0);
        dw[2] = 24'd0;
        run_sched(2, 32'd0);
        dw[0] = 24'd0;
        run_sched(0, fq[1]);
        t_busy_go();
        t_rst_mid();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule